// File: doc/BRIEF.md
# Flash-ADC Pixel Encoder with Zero-Suppressed Column Readout

This block is the digital back end of a group of tracking-detector pixels that share one readout path at the edge of a column. Every pixel delivers seven comparator outputs that form a thermometer code. On each edge of the bunch-crossing clock the pixel turns that code into a 3-bit amplitude. A pixel that has any comparator set raises a readout request. Each pixel holds two configuration bits. One bit silences the pixel. The other injects a full-scale test hit whatever the comparators show.

Requests are captured only when the group has nothing left to read out. A lowest-index-first priority encoder then drains the captured requests at one pixel per clock. For each granted pixel it presents the pixel address and amplitude with a valid flag, and it clears that request. Pixels without a hit never use a readout slot. A busy flag shows that an event is still draining, and comparator activity during that time is not recorded.

Top module: `pix_sparse_rdo`

## Requirements
- R1: A pixel's amplitude is the number of ones among its seven comparator lines (0 to 7), so a code with gaps (for example 1010001, amplitude 3) is handled as well as a clean one.
- R2: A pixel that is neither forced nor has any comparator line set raises no request and is never reported.
- R3: A pixel whose configuration bit 0 (mask) is 1 is never reported, whatever its comparator lines are and even when bit 1 is also set.
- R4: A pixel with configuration bit 1 (force) at 1 and bit 0 at 0 is reported at every capture, with amplitude 7, even when its comparator lines are all zero.
- R5: The captured requests come out one per clock, in strictly ascending pixel index, with no gap between words of one event, and every address is below the pixel count.
- R6: Comparator lines are sampled on a clock edge at which no request is pending. The first word of that event appears with rd_valid high after the following edge.
- R7: Comparator lines and their changes at edges where a request is still pending have no effect on what is read out.
- R8: busy is high exactly while captured requests remain unread. It falls at the edge that presents the last word of an event.
- R9: After reset rd_valid and busy are low and every pixel has configuration 00. rd_valid is low at every edge where no word is presented.
- R10: When cfg_wr is high at an edge, cfg_val is stored for pixel cfg_addr and is used from the next edge onward. A cfg_addr at or above the pixel count changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock, 25 ns |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Pixel index for the configuration write |
| cfg_val | input | 2 | Configuration value: bit 0 mask, bit 1 force |
| thermo_i | input | 1344 | Comparator lines, 7 per pixel, pixel p at bits [7p+6:7p] |
| rd_valid | output | 1 | A readout word is presented |
| rd_addr | output | 8 | Index of the reported pixel |
| rd_amp | output | 3 | Amplitude of the reported pixel |
| busy | output | 1 | Captured requests are still pending |

## Verification
The assertions assume that reset is held for at least one edge before normal operation. They also assume that cfg_addr, cfg_val and the comparator lines are stable around each edge. The stimulus meets both conditions by changing inputs only on the falling clock edge. It holds reset for several cycles at the start, and it uses only addresses that fit the 8-bit port. That includes out-of-range addresses, so the write rejection is exercised. Random comparator activity is applied every cycle, including while a readout is in progress, and the reference model in the bench samples it only at the edges where it expects a capture.

// File: rtl/pix_sparse_rdo.sv
`timescale 1ns/1ps
module pix_sparse_rdo #(
  parameter int NPIX = 192,
  parameter int NCMP = 7,
  localparam int AW   = $clog2(NPIX),
  localparam int AMPW = $clog2(NCMP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [1:0]           cfg_val,
  input  logic [NPIX*NCMP-1:0] thermo_i,
  output logic                 rd_valid,
  output logic [AW-1:0]        rd_addr,
  output logic [AMPW-1:0]      rd_amp,
  output logic                 busy
);

  function automatic logic [AMPW-1:0] ones(input logic [NCMP-1:0] v);
    logic [AMPW-1:0] c;
    c = '0;
    for (int k = 0; k < NCMP; k++) c = c + AMPW'(v[k]);
    return c;
  endfunction

  logic [1:0]      cfg_q [NPIX];
  logic [AMPW-1:0] amp_q [NPIX];
  logic [AMPW-1:0] amp_w [NPIX];
  logic [NPIX-1:0] req_q, hit_w, gnt;
  logic [AW-1:0]   sel;

  assign busy = |req_q;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic [NCMP-1:0] th;
    assign th       = thermo_i[p*NCMP +: NCMP];
    assign hit_w[p] = !cfg_q[p][0] && (cfg_q[p][1] || (|th));
    assign amp_w[p] = cfg_q[p][1] ? AMPW'(NCMP) : ones(th);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[p] <= 2'b00;
        req_q[p] <= 1'b0;
        amp_q[p] <= '0;
      end else begin
        if (cfg_wr && cfg_addr == AW'(p)) cfg_q[p] <= cfg_val;
        if (!busy) begin
          req_q[p] <= hit_w[p];
          amp_q[p] <= amp_w[p];
        end else if (gnt[p]) begin
          req_q[p] <= 1'b0;
        end
      end
    end

    assert_mask_silences_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q[p]) |-> !$past(cfg_q[p][0]));
  end

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    sel   = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (req_q[i] && !found) begin
        found  = 1'b1;
        gnt[i] = 1'b1;
        sel    = AW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_amp   <= '0;
    end else begin
      rd_valid <= busy;
      if (busy) begin
        rd_addr <= sel;
        rd_amp  <= amp_q[sel];
      end
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> (rd_addr > $past(rd_addr)));
  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_addr) < NPIX));
  assert_drain_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(req_q) == $countones($past(req_q)) - 1));
  assert_busy_gives_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rd_valid);
  assert_idle_no_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rd_valid);

endmodule

// File: tb/pix_sparse_rdo_tb.sv
`timescale 1ns/1ps
module pix_sparse_rdo_tb;
  localparam real CLK_NS = 25.0;
  localparam int  NPIX = 192;
  localparam int  NCMP = 7;
  localparam int  AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [1:0] cfg_val = '0;
  logic [NPIX*NCMP-1:0] th = '0;
  logic rd_valid, busy;
  logic [AW-1:0] rd_addr;
  logic [2:0] rd_amp;

  pix_sparse_rdo #(.NPIX(NPIX), .NCMP(NCMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_val(cfg_val), .thermo_i(th), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_amp(rd_amp), .busy(busy));

  always #(CLK_NS/2.0) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string phase = "init";

  logic [1:0] cfg_m [NPIX];
  int q_addr[$], q_amp[$], q_frc[$];
  bit exp_v = 0, exp_busy = 0;
  int exp_a = 0, exp_m = 0, exp_f = 0;

  function automatic int ones7(logic [6:0] v);
    int c = 0;
    for (int k = 0; k < 7; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", tag, phase, act, expv);
    end
  endtask

  // reference model of the event capture and drain
  always @(posedge clk) begin
    if (!rst_n) begin
      q_addr.delete(); q_amp.delete(); q_frc.delete();
      exp_v = 0; exp_busy = 0;
      for (int p = 0; p < NPIX; p++) cfg_m[p] = 2'b00;
    end else begin
      if (q_addr.size() == 0) begin
        exp_v = 0;
        for (int p = 0; p < NPIX; p++) begin
          logic [6:0] t;
          t = th[p*NCMP +: NCMP];
          if (cfg_m[p][0]) continue;
          if (cfg_m[p][1]) begin
            q_addr.push_back(p); q_amp.push_back(7); q_frc.push_back(1);
          end else if (t != 0) begin
            q_addr.push_back(p); q_amp.push_back(ones7(t)); q_frc.push_back(0);
          end
        end
      end else begin
        exp_v = 1;
        exp_a = q_addr.pop_front();
        exp_m = q_amp.pop_front();
        exp_f = q_frc.pop_front();
      end
      if (cfg_wr && int'(cfg_addr) < NPIX) cfg_m[cfg_addr] = cfg_val;
      exp_busy = (q_addr.size() != 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(exp_v ? "R6 valid" : "R9 valid low", int'(rd_valid), int'(exp_v));
      chk("R8 busy", int'(busy), int'(exp_busy));
      if (exp_v && rd_valid) begin
        chk("R5 address order", int'(rd_addr), exp_a);
        chk(exp_f ? "R4 forced amplitude" : "R1 amplitude", int'(rd_amp), exp_m);
      end
    end
  end

  task automatic wr_cfg(int a, logic [1:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_val = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q_addr.size() != 0 || busy);
    @(negedge clk);
  endtask

  task automatic event_pulse(logic [NPIX*NCMP-1:0] v, bit junk);
    wait_idle();
    th = v;
    @(negedge clk);
    if (junk) begin
      while (busy) begin
        for (int p = 0; p < NPIX; p++) th[p*NCMP +: NCMP] = 7'($urandom);
        @(negedge clk);
      end
    end
    th = '0;
    wait_idle();
  endtask

  initial begin
    #(CLK_NS * 200000.0);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NPIX*NCMP-1:0] v;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    phase = "R9 reset";
    chk("R9 reset valid", int'(rd_valid), 0);
    chk("R9 reset busy", int'(busy), 0);
    rst_n = 1'b1;

    phase = "R2 no hits";
    repeat (5) @(negedge clk);
    chk("R2 idle busy", int'(busy), 0);

    phase = "R1 codes";
    v = '0;
    v[0*7 +: 7]   = 7'b0000111;
    v[50*7 +: 7]  = 7'b1111111;
    v[191*7 +: 7] = 7'b1010001;
    event_pulse(v, 0);

    phase = "R3 mask";
    wr_cfg(5, 2'b01);
    wr_cfg(7, 2'b11);
    v = '0;
    v[5*7 +: 7] = 7'b0011111;
    v[6*7 +: 7] = 7'b0000001;
    v[7*7 +: 7] = 7'b1111111;
    event_pulse(v, 0);
    chk("R3 masked busy after drain", int'(busy), 0);

    phase = "R4 force";
    wr_cfg(9, 2'b10);
    v = '0;
    v[3*7 +: 7] = 7'b0000011;
    event_pulse(v, 0);
    repeat (6) @(negedge clk);
    wr_cfg(9, 2'b00);
    wait_idle();

    phase = "R10 out of range write";
    wr_cfg(200, 2'b01);
    wr_cfg(255, 2'b10);
    v = '0;
    v[190*7 +: 7] = 7'b0000100;
    event_pulse(v, 0);

    phase = "R7 junk during readout";
    v = '0;
    v[10*7 +: 7] = 7'b0001111;
    v[11*7 +: 7] = 7'b0100000;
    v[100*7 +: 7] = 7'b1111110;
    event_pulse(v, 1);

    phase = "R5 all pixels";
    v = '1;
    event_pulse(v, 0);

    phase = "R1 R3 R4 R5 R7 R10 random";
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      for (int p = 0; p < NPIX; p++)
        th[p*NCMP +: NCMP] = ($urandom % 100 < 3) ? 7'($urandom) : 7'd0;
      if ($urandom % 8 == 0) begin
        cfg_wr = 1'b1;
        cfg_addr = AW'($urandom);
        cfg_val = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      end else begin
        cfg_wr = 1'b0;
      end
    end
    cfg_wr = 1'b0;
    th = '0;
    for (int p = 0; p < NPIX; p++) wr_cfg(p, 2'b00);
    wait_idle();
    wait_idle();
    chk("R8 final idle", int'(busy), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule